// File: doc/BRIEF.md
# SIMD One-Register Modified-Immediate Decoder

This block sits in the decode stage of a SIMD front end. Each cycle it may receive a 32-bit instruction word, marked by a valid strobe. It decides whether the word belongs to the group of vector instructions that write one register with a modified immediate. For words in that group it pulls out the destination register number, the 8-bit packed immediate, the cmode selector, the op bit and the quad bit. It then sorts the instruction into one of three classes: OR with the immediate, AND with the inverted immediate, or move-immediate.

The block also flags undefined encodings. These are the single unallocated cmode/op pair, a quad operation that names an odd register, and a register in the upper half of the file when that half is not present. All results are registered and appear one cycle after the strobe. Expanding the immediate and writing the register file are the job of later stages.

Top module: `simd_imm1r_decoder`

## Requirements
- R1: Out of reset every output is zero. `dec_valid_o` is high in exactly those cycles that follow a clock edge at which `insn_valid_i` was high, so results appear one cycle after the strobe.
- R2: `match_o` is 1 exactly when instruction bits 31:25 = 1111001, bit 23 = 1, bits 21:19 = 000, bit 7 = 0 and bit 4 = 1.
- R3: For a matching word, `imm_o` = {bit 24, bits 18:16, bits 3:0}, `vd_o` = {bit 22, bits 15:12}, `cmode_o` = bits 11:8, `op_o` = bit 5 and `quad_o` = bit 6. For a word that does not match, all fields and `vec_bytes_o` are 0, `op_class_o` = 11 and `undef_o` = 0.
- R4: For a match with op = 0, odd cmode and cmode < 12, `op_class_o` = 00 (OR with the immediate).
- R5: For a match with op = 1, odd cmode and cmode < 12, `op_class_o` = 01 (AND with the inverted immediate).
- R6: Every other matching cmode/op pair gives `op_class_o` = 10 (move), except cmode = 15 with op = 1. That pair gives `op_class_o` = 11 and `undef_o` = 1.
- R7: A match with quad = 1 and an odd destination register sets `undef_o`.
- R8: A match with `upper_regs_i` = 0 and destination bit 4 set sets `undef_o`. With `upper_regs_i` = 1, that register alone does not make the instruction undefined.
- R9: For a match, `vec_bytes_o` is 16 when quad = 1 and 8 when quad = 0.
- R10: In a cycle that follows an edge with `insn_valid_i` low, every output except `dec_valid_o` holds the value it had before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid_i | input | 1 | Instruction word valid strobe |
| insn_i | input | 32 | Instruction word |
| upper_regs_i | input | 1 | High when doubleword registers 16 to 31 exist |
| dec_valid_o | output | 1 | Decoded result valid |
| match_o | output | 1 | Word belongs to the one-register immediate group |
| undef_o | output | 1 | Matching word is an undefined encoding |
| op_class_o | output | 2 | 00 OR, 01 AND-inverted, 10 move, 11 reserved |
| vd_o | output | 5 | Destination register number |
| imm_o | output | 8 | Packed 8-bit immediate |
| cmode_o | output | 4 | cmode selector |
| op_o | output | 1 | op bit |
| quad_o | output | 1 | Quad (128-bit) operation |
| vec_bytes_o | output | 5 | Bytes written: 16 for quad, 8 otherwise |

## Verification
The bench builds the block with its default parameters: an 8-byte doubleword, which gives 16-byte quad operations. With these values every cmode/op pair can be reached directly, as can the quad/odd-register and upper-register conditions with the configuration bit set both ways. Words that sit just outside the group pattern are also reachable, as are back-to-back strobes mixed with idle cycles, which exercise the hold behaviour.

// File: rtl/simd_imm1r_pkg.sv
package simd_imm1r_pkg;
    localparam int INSN_W  = 32;
    localparam int IMM_W   = 8;
    localparam int REG_W   = 5;
    localparam int CMODE_W = 4;
    localparam int BYTES_W = 5;

    typedef enum logic [1:0] {
        CLS_OR   = 2'b00,
        CLS_ANDN = 2'b01,
        CLS_MOVE = 2'b10,
        CLS_RSVD = 2'b11
    } op_class_e;

    typedef struct packed {
        logic                valid;
        logic                match;
        logic                undef;
        op_class_e           op_class;
        logic [REG_W-1:0]    vd;
        logic [IMM_W-1:0]    imm;
        logic [CMODE_W-1:0]  cmode;
        logic                op;
        logic                quad;
        logic [BYTES_W-1:0]  bytes;
    } dec_t;
endpackage

// File: rtl/simd_imm1r_fields.sv
module simd_imm1r_fields
    import simd_imm1r_pkg::*;
(
    input  logic [INSN_W-1:0]  insn_i,
    output logic               hit_o,
    output logic [REG_W-1:0]   vd_o,
    output logic [IMM_W-1:0]   imm_o,
    output logic [CMODE_W-1:0] cmode_o,
    output logic               op_o,
    output logic               quad_o
);
    localparam logic [INSN_W-1:0] FIXED_MASK = 32'hFEB8_0090;
    localparam logic [INSN_W-1:0] FIXED_BITS = 32'hF280_0010;

    always_comb begin
        hit_o   = ((insn_i & FIXED_MASK) == FIXED_BITS);
        imm_o   = {insn_i[24], insn_i[18:16], insn_i[3:0]};
        vd_o    = {insn_i[22], insn_i[15:12]};
        cmode_o = insn_i[11:8];
        op_o    = insn_i[5];
        quad_o  = insn_i[6];
    end
endmodule

// File: rtl/simd_imm1r_classify.sv
module simd_imm1r_classify
    import simd_imm1r_pkg::*;
(
    input  logic [CMODE_W-1:0] cmode_i,
    input  logic               op_i,
    input  logic               quad_i,
    input  logic [REG_W-1:0]   vd_i,
    input  logic               upper_regs_i,
    output op_class_e          op_class_o,
    output logic               undef_o
);
    localparam logic [CMODE_W-1:0] MOD_LIMIT = 4'd12;
    localparam logic [CMODE_W-1:0] FP_CMODE  = 4'd15;

    logic logic_form;
    logic unalloc;
    logic bad_align;
    logic bad_bank;

    always_comb begin
        logic_form = cmode_i[0] && (cmode_i < MOD_LIMIT);
        unalloc    = (cmode_i == FP_CMODE) && op_i;
        if (logic_form) begin
            op_class_o = op_i ? CLS_ANDN : CLS_OR;
        end else if (unalloc) begin
            op_class_o = CLS_RSVD;
        end else begin
            op_class_o = CLS_MOVE;
        end
        bad_align = quad_i && vd_i[0];
        bad_bank  = !upper_regs_i && vd_i[REG_W-1];
        undef_o   = unalloc || bad_align || bad_bank;
    end
endmodule

// File: rtl/simd_imm1r_size.sv
module simd_imm1r_size
    import simd_imm1r_pkg::*;
#(
    parameter int D_BYTES = 8
) (
    input  logic               quad_i,
    output logic [BYTES_W-1:0] bytes_o
);
    localparam int Q_BYTES = 2 * D_BYTES;

    always_comb begin
        bytes_o = quad_i ? BYTES_W'(Q_BYTES) : BYTES_W'(D_BYTES);
    end
endmodule

// File: rtl/simd_imm1r_decoder.sv
module simd_imm1r_decoder
    import simd_imm1r_pkg::*;
#(
    parameter int D_BYTES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               insn_valid_i,
    input  logic [31:0]        insn_i,
    input  logic               upper_regs_i,
    output logic               dec_valid_o,
    output logic               match_o,
    output logic               undef_o,
    output logic [1:0]         op_class_o,
    output logic [4:0]         vd_o,
    output logic [7:0]         imm_o,
    output logic [3:0]         cmode_o,
    output logic               op_o,
    output logic               quad_o,
    output logic [4:0]         vec_bytes_o
);
    logic               hit;
    logic [REG_W-1:0]   f_vd;
    logic [IMM_W-1:0]   f_imm;
    logic [CMODE_W-1:0] f_cmode;
    logic               f_op;
    logic               f_quad;
    op_class_e          c_class;
    logic               c_undef;
    logic [BYTES_W-1:0] s_bytes;

    dec_t dec_d;
    dec_t dec_q;

    simd_imm1r_fields u_fields (
        .insn_i  (insn_i),
        .hit_o   (hit),
        .vd_o    (f_vd),
        .imm_o   (f_imm),
        .cmode_o (f_cmode),
        .op_o    (f_op),
        .quad_o  (f_quad)
    );

    simd_imm1r_classify u_classify (
        .cmode_i      (f_cmode),
        .op_i         (f_op),
        .quad_i       (f_quad),
        .vd_i         (f_vd),
        .upper_regs_i (upper_regs_i),
        .op_class_o   (c_class),
        .undef_o      (c_undef)
    );

    simd_imm1r_size #(.D_BYTES(D_BYTES)) u_size (
        .quad_i  (f_quad),
        .bytes_o (s_bytes)
    );

    always_comb begin
        dec_d       = dec_q;
        dec_d.valid = insn_valid_i;
        if (insn_valid_i) begin
            if (hit) begin
                dec_d.match    = 1'b1;
                dec_d.undef    = c_undef;
                dec_d.op_class = c_class;
                dec_d.vd       = f_vd;
                dec_d.imm      = f_imm;
                dec_d.cmode    = f_cmode;
                dec_d.op       = f_op;
                dec_d.quad     = f_quad;
                dec_d.bytes    = s_bytes;
            end else begin
                dec_d          = '0;
                dec_d.valid    = 1'b1;
                dec_d.op_class = CLS_RSVD;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign dec_valid_o = dec_q.valid;
    assign match_o     = dec_q.match;
    assign undef_o     = dec_q.undef;
    assign op_class_o  = dec_q.op_class;
    assign vd_o        = dec_q.vd;
    assign imm_o       = dec_q.imm;
    assign cmode_o     = dec_q.cmode;
    assign op_o        = dec_q.op;
    assign quad_o      = dec_q.quad;
    assign vec_bytes_o = dec_q.bytes;
endmodule

// File: rtl/simd_imm1r_checker.sv
module simd_imm1r_checker #(
    parameter int D_BYTES = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        insn_valid_i,
    input logic [31:0] insn_i,
    input logic        upper_regs_i,
    input logic        dec_valid_o,
    input logic        match_o,
    input logic        undef_o,
    input logic [1:0]  op_class_o,
    input logic [4:0]  vd_o,
    input logic [7:0]  imm_o,
    input logic [3:0]  cmode_o,
    input logic        op_o,
    input logic        quad_o,
    input logic [4:0]  vec_bytes_o
);
    p_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid_i |=> dec_valid_o);
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_valid_i |=> !dec_valid_o);
    p_nomatch_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && !match_o) |-> (!undef_o && op_class_o == 2'b11 && vd_o == 5'd0));
    p_or_class_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && match_o && cmode_o[0] && cmode_o < 4'd12 && !op_o) |-> op_class_o == 2'b00);
    p_andn_class_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && match_o && cmode_o[0] && cmode_o < 4'd12 && op_o) |-> op_class_o == 2'b01);
    p_even_move_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && match_o && !cmode_o[0]) |-> op_class_o == 2'b10);
    p_rsvd_undef_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && match_o && op_class_o == 2'b11) |-> undef_o);
    p_quad_odd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && match_o && quad_o && vd_o[0]) |-> undef_o);
    p_quad_size_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && match_o) |-> (vec_bytes_o == (quad_o ? 5'(2 * D_BYTES) : 5'(D_BYTES))));
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_valid_i |=> ($stable(imm_o) && $stable(vd_o) && $stable(op_class_o) && $stable(undef_o)));
endmodule

bind simd_imm1r_decoder simd_imm1r_checker #(.D_BYTES(D_BYTES)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .insn_valid_i (insn_valid_i),
    .insn_i       (insn_i),
    .upper_regs_i (upper_regs_i),
    .dec_valid_o  (dec_valid_o),
    .match_o      (match_o),
    .undef_o      (undef_o),
    .op_class_o   (op_class_o),
    .vd_o         (vd_o),
    .imm_o        (imm_o),
    .cmode_o      (cmode_o),
    .op_o         (op_o),
    .quad_o       (quad_o),
    .vec_bytes_o  (vec_bytes_o)
);

// File: tb/simd_imm1r_decoder_tb.sv
`timescale 1ns/1ps
module simd_imm1r_decoder_tb_top;
    import simd_imm1r_pkg::*;

    typedef struct {
        dec_t  e;
        string tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid_i = 1'b0;
    logic [31:0] insn_i = '0;
    logic        upper_regs_i = 1'b1;
    logic        dec_valid_o, match_o, undef_o, op_o, quad_o;
    logic [1:0]  op_class_o;
    logic [4:0]  vd_o, vec_bytes_o;
    logic [7:0]  imm_o;
    logic [3:0]  cmode_o;

    int    n_tests = 0;
    int    n_fail  = 0;
    item_t sb_q[$];
    item_t last;
    bit    have_last = 1'b0;
    bit    mon_on = 1'b0;
    bit    done = 1'b0;
    int    cycles = 0;

    always #4 clk = ~clk;

    simd_imm1r_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .insn_valid_i(insn_valid_i), .insn_i(insn_i),
        .upper_regs_i(upper_regs_i), .dec_valid_o(dec_valid_o), .match_o(match_o),
        .undef_o(undef_o), .op_class_o(op_class_o), .vd_o(vd_o), .imm_o(imm_o),
        .cmode_o(cmode_o), .op_o(op_o), .quad_o(quad_o), .vec_bytes_o(vec_bytes_o)
    );

    function automatic logic [31:0] mk(bit i, bit d, logic [2:0] ih, logic [3:0] vd,
                                       logic [3:0] cm, bit q, bit op, logic [3:0] il);
        return {7'b1111001, i, 1'b1, d, 3'b000, ih, vd, cm, 1'b0, q, op, 1'b1, il};
    endfunction

    // Reference model written from the requirements
    function automatic dec_t model(logic [31:0] w, bit up);
        dec_t r;
        bit hit;
        r = '0;
        r.valid = 1'b1;
        hit = (w[31:25] == 7'b1111001) && w[23] && (w[21:19] == 3'b000) && !w[7] && w[4];
        if (!hit) begin
            r.op_class = CLS_RSVD;                                  // R3
            return r;
        end
        r.match = 1'b1;                                             // R2
        r.imm   = {w[24], w[18:16], w[3:0]};                        // R3
        r.vd    = {w[22], w[15:12]};
        r.cmode = w[11:8];
        r.op    = w[5];
        r.quad  = w[6];
        if (r.cmode[0] && r.cmode < 4'd12) r.op_class = r.op ? CLS_ANDN : CLS_OR;  // R4 R5
        else if (r.cmode == 4'd15 && r.op) r.op_class = CLS_RSVD;                   // R6
        else r.op_class = CLS_MOVE;
        r.undef = (r.op_class == CLS_RSVD) || (r.quad && r.vd[0]) || (!up && r.vd[4]); // R7 R8
        r.bytes = r.quad ? 5'd16 : 5'd8;                            // R9
        return r;
    endfunction

    function automatic dec_t actual();
        dec_t a;
        a.valid = dec_valid_o; a.match = match_o; a.undef = undef_o;
        a.op_class = op_class_e'(op_class_o); a.vd = vd_o; a.imm = imm_o;
        a.cmode = cmode_o; a.op = op_o; a.quad = quad_o; a.bytes = vec_bytes_o;
        return a;
    endfunction

    task automatic send(logic [31:0] w, bit up, string tag);
        item_t it;
        @(negedge clk);
        insn_i = w;
        upper_regs_i = up;
        insn_valid_i = 1'b1;
        it.e = model(w, up);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            insn_valid_i = 1'b0;
            insn_i = $urandom;
        end
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on) begin
                dec_t a;
                a = actual();
                if (dec_valid_o) begin
                    n_tests++;
                    if (sb_q.size() == 0) begin
                        n_fail++;
                        $display("FAIL R1: unexpected dec_valid_o act=%h exp=no result", a);
                    end else begin
                        item_t it;
                        it = sb_q.pop_front();
                        if (a !== it.e) begin
                            n_fail++;
                            $display("FAIL %s: act=%h exp=%h", it.tag, a, it.e);
                        end
                        last = it;
                        have_last = 1'b1;
                    end
                end else if (have_last) begin
                    dec_t ex;
                    ex = last.e;
                    ex.valid = 1'b0;
                    n_tests++;
                    if (a !== ex) begin
                        n_fail++;
                        $display("FAIL R10: hold act=%h exp=%h", a, ex);
                    end
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: act=%0d cycles exp=completion", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_tests++;
        if (actual() !== dec_t'('0)) begin
            n_fail++;
            $display("FAIL R1: reset act=%h exp=%h", actual(), dec_t'('0));
        end
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R4 R5 R6: every cmode/op pair, doubleword, even register
        for (int cm = 0; cm < 16; cm++) begin
            for (int op = 0; op < 2; op++) begin
                send(mk(1'b1, 1'b0, 3'b010, 4'd2, cm[3:0], 1'b0, op[0], 4'hA), 1'b1, "R4_R5_R6 class");
            end
        end
        idle(2);
        // R3: immediate and register fields
        send(mk(1'b0, 1'b1, 3'b101, 4'd6, 4'd14, 1'b0, 1'b1, 4'h3), 1'b1, "R3 fields");
        send(mk(1'b1, 1'b0, 3'b000, 4'd0, 4'd0, 1'b0, 1'b0, 4'h0), 1'b1, "R3 zero imm");
        // R7 R9: quad with odd and even registers
        send(mk(1'b0, 1'b0, 3'b111, 4'd3, 4'd1, 1'b1, 1'b0, 4'hF), 1'b1, "R7 quad odd");
        send(mk(1'b0, 1'b0, 3'b111, 4'd4, 4'd1, 1'b1, 1'b0, 4'hF), 1'b1, "R9 quad even");
        idle(1);
        // R8: upper bank present or absent
        send(mk(1'b0, 1'b1, 3'b001, 4'd2, 4'd14, 1'b0, 1'b0, 4'h1), 1'b0, "R8 upper absent");
        send(mk(1'b0, 1'b1, 3'b001, 4'd2, 4'd14, 1'b0, 1'b0, 4'h1), 1'b1, "R8 upper present");
        send(mk(1'b0, 1'b0, 3'b001, 4'd2, 4'd14, 1'b0, 1'b0, 4'h1), 1'b0, "R8 lower bank");
        idle(3);
        // R2 R3: near misses of the group pattern
        send(mk(1'b0, 1'b0, 3'b001, 4'd2, 4'd2, 1'b0, 1'b0, 4'h1) | 32'h0000_0080, 1'b1, "R2 bit7 set");
        send(mk(1'b0, 1'b0, 3'b001, 4'd2, 4'd2, 1'b0, 1'b0, 4'h1) & ~32'h0000_0010, 1'b1, "R2 bit4 clear");
        send(mk(1'b0, 1'b0, 3'b001, 4'd2, 4'd2, 1'b0, 1'b0, 4'h1) | 32'h0008_0000, 1'b1, "R2 bit19 set");
        send(mk(1'b0, 1'b0, 3'b001, 4'd2, 4'd2, 1'b0, 1'b0, 4'h1) & ~32'h0080_0000, 1'b1, "R2 bit23 clear");
        send(mk(1'b0, 1'b0, 3'b001, 4'd2, 4'd2, 1'b0, 1'b0, 4'h1) ^ 32'h0200_0000, 1'b1, "R2 top bits");
        idle(2);
        // Random mix, half forced into the group
        for (int k = 0; k < 400; k++) begin
            logic [31:0] w;
            w = $urandom;
            if (k % 2 == 0) w = (w & ~32'hFEB8_0090) | 32'hF280_0010;
            send(w, 1'($urandom), "R2_R3_R7_R8 random");
            if (k % 7 == 0) idle(1);
        end
        idle(4);
        n_tests++;
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL R1: results outstanding act=%0d exp=0", sb_q.size());
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule